// File: doc/BRIEF.md
# Signed-Count Shift Unit with Flags

This block shifts a data word by a signed count in a single cycle and registers the result. The sign of the count sets the direction: a non-negative count shifts left and a negative count shifts right by its magnitude. The most negative count, equal to minus the data width, moves every bit out of the word.

A mode bit selects between two modes. The logical mode fills vacated positions with zeros and leaves the status flags alone. The arithmetic mode fills from the sign on right shifts. It also updates five status flags: carry, overflow, sticky overflow, advance overflow and sticky advance overflow.

A caller presents a word, a count and the mode with a one-cycle valid strobe. The result and the flags appear on the registered outputs at the next rising clock edge.

Top module: `sc_shift_top`

## Requirements
- R1: After a synchronous active-high reset, the result and all five flags are zero.
- R2: In logical mode (`arith_mode`=0), a count of n>=0 gives the data shifted left by n with zero fill. A count of -m gives a zero-filled right shift by m. A count of -32 gives zero.
- R3: In arithmetic mode with a count n>0, the result is the data shifted left by n. Carry is 1 exactly when any of the top n input bits is 1.
- R4: In arithmetic mode with a count n>0, overflow is 1 when the signed input is greater than 0x7FFFFFFF arithmetically shifted right by n, or less than 0x80000000 arithmetically shifted right by n. Sticky overflow becomes the OR of its old value and the new overflow, and once set it stays set until reset.
- R5: In arithmetic mode with a count -m (0<m<32), the result is the data arithmetically shifted right by m. Overflow is cleared. Carry is 1 exactly when any of the low m input bits is 1.
- R6: In arithmetic mode with a count of -32, every result bit equals input bit 31. Overflow is cleared. Carry is 1 when the input is non-zero.
- R7: In arithmetic mode with a count of 0, the result equals the input and both carry and overflow are cleared.
- R8: After every arithmetic operation, advance overflow equals result bit 31 XOR result bit 30. Sticky advance overflow becomes the OR of its old value and the new advance overflow.
- R9: A logical-mode operation leaves all five flags unchanged.
- R10: The outputs update one clock edge after a cycle with `in_valid`=1. In a cycle with `in_valid`=0, the result and the flags keep their values.

The count is the two's complement value of `in_count`, in the range -32..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| arith_mode | input | 1 | 1 = arithmetic, 0 = logical |
| in_data | input | 32 | Operand |
| in_count | input | 6 | Signed shift count, two's complement |
| out_data | output | 32 | Registered shift result |
| flag_carry | output | 1 | Carry: some shifted-out bit was 1 |
| flag_ovf | output | 1 | Overflow of the last arithmetic left shift |
| flag_sticky_ovf | output | 1 | Accumulated overflow |
| flag_adv_ovf | output | 1 | Result bit 31 XOR bit 30 |
| flag_sticky_adv | output | 1 | Accumulated advance overflow |

## Verification
The bench builds the block with its default 32-bit data width. The count width is derived from the data width as 6 bits, so every count from -32 to 31 can be driven. This covers the all-bits-out case at -32 and the largest left shift of 31, where the overflow limits shrink to 0 and -1. Directed operands sit exactly on, and one step past, both shifted overflow limits for several counts. Random operands and counts then exercise both modes, with idle cycles mixed in to show that the outputs and the sticky flags hold.

// File: rtl/sc_shift_pkg.sv
package sc_shift_pkg;

  typedef struct packed {
    logic carry;
    logic ovf;
    logic sticky_ovf;
    logic adv;
    logic sticky_adv;
  } sc_flags_t;

  function automatic int sc_cnt_width(input int data_w);
    return $clog2(data_w) + 1;
  endfunction

endpackage

// File: rtl/sc_shift_core.sv
module sc_shift_core #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  count,
  input  logic              arith,
  output logic [DATA_W-1:0] result,
  output logic [CNT_W-1:0]  mag,
  output logic              go_left
);
  localparam int STAGES = CNT_W;

  logic                          fill;
  logic [STAGES:0][DATA_W-1:0]   lv;
  logic [STAGES:0][DATA_W-1:0]   rv;

  assign go_left = ~count[CNT_W-1];
  assign mag     = go_left ? count : (~count + {{(CNT_W-1){1'b0}}, 1'b1});
  assign fill    = arith & data[DATA_W-1];

  assign lv[0] = data;
  assign rv[0] = data;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int SH = 1 << k;
    if (SH < DATA_W) begin : g_part
      assign lv[k+1] = mag[k] ? {lv[k][DATA_W-1-SH:0], {SH{1'b0}}} : lv[k];
      assign rv[k+1] = mag[k] ? {{SH{fill}}, rv[k][DATA_W-1:SH]} : rv[k];
    end else begin : g_full
      assign lv[k+1] = mag[k] ? '0 : lv[k];
      assign rv[k+1] = mag[k] ? {DATA_W{fill}} : rv[k];
    end
  end

  assign result = go_left ? lv[STAGES] : rv[STAGES];

endmodule

// File: rtl/sc_flag_calc.sv
module sc_flag_calc #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CNT_W-1:0]  mag,
  input  logic              go_left,
  input  logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              ovf,
  output logic              adv
);
  localparam logic [DATA_W-1:0] ONES    = '1;
  localparam logic [DATA_W-1:0] POS_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]        out_mask;
  logic signed [DATA_W-1:0] hi_lim;
  logic signed [DATA_W-1:0] lo_lim;
  logic signed [DATA_W-1:0] sdata;

  // bits leaving the word: top mag bits on a left shift, low mag bits on a right shift
  assign out_mask = go_left ? ~(ONES >> mag) : ~(ONES << mag);
  assign carry    = |(data & out_mask);

  assign sdata  = $signed(data);
  assign hi_lim = $signed(POS_MAX) >>> mag;
  assign lo_lim = $signed(NEG_MIN) >>> mag;
  assign ovf    = go_left & ((sdata > hi_lim) | (sdata < lo_lim));

  assign adv = result[DATA_W-1] ^ result[DATA_W-2];

endmodule

// File: rtl/sc_flag_reg.sv
module sc_flag_reg
  import sc_shift_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      upd,
  input  logic      carry_n,
  input  logic      ovf_n,
  input  logic      adv_n,
  output sc_flags_t flags
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else if (upd) begin
      flags.carry      <= carry_n;
      flags.ovf        <= ovf_n;
      flags.sticky_ovf <= flags.sticky_ovf | ovf_n;
      flags.adv        <= adv_n;
      flags.sticky_adv <= flags.sticky_adv | adv_n;
    end
  end

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(flags));
  assert_sticky_ovf_keep_R4: assert property (@(posedge clk) disable iff (rst)
    flags.sticky_ovf |=> flags.sticky_ovf);
  assert_ovf_in_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    flags.ovf |-> flags.sticky_ovf);
  assert_sticky_adv_keep_R8: assert property (@(posedge clk) disable iff (rst)
    flags.sticky_adv |=> flags.sticky_adv);
  assert_adv_in_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    flags.adv |-> flags.sticky_adv);

endmodule

// File: rtl/sc_shift_top.sv
module sc_shift_top
  import sc_shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = sc_cnt_width(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              arith_mode,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  in_count,
  output logic [DATA_W-1:0] out_data,
  output logic              flag_carry,
  output logic              flag_ovf,
  output logic              flag_sticky_ovf,
  output logic              flag_adv_ovf,
  output logic              flag_sticky_adv
);

  logic [DATA_W-1:0] shifted;
  logic [CNT_W-1:0]  mag;
  logic              go_left;
  logic              carry_n, ovf_n, adv_n;
  sc_flags_t         flags;

  sc_shift_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .data(in_data), .count(in_count), .arith(arith_mode),
    .result(shifted), .mag(mag), .go_left(go_left)
  );

  sc_flag_calc #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_calc (
    .data(in_data), .mag(mag), .go_left(go_left), .result(shifted),
    .carry(carry_n), .ovf(ovf_n), .adv(adv_n)
  );

  sc_flag_reg u_flags (
    .clk(clk), .rst(rst), .upd(in_valid & arith_mode),
    .carry_n(carry_n), .ovf_n(ovf_n), .adv_n(adv_n), .flags(flags)
  );

  always_ff @(posedge clk) begin
    if (rst)           out_data <= '0;
    else if (in_valid) out_data <= shifted;
  end

  assign flag_carry      = flags.carry;
  assign flag_ovf        = flags.ovf;
  assign flag_sticky_ovf = flags.sticky_ovf;
  assign flag_adv_ovf    = flags.adv;
  assign flag_sticky_adv = flags.sticky_adv;

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  assert_zero_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode && in_count == '0)
      |=> (out_data == $past(in_data)) && !flag_carry && !flag_ovf);
  assert_right_no_ovf_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode && in_count[CNT_W-1]) |=> !flag_ovf);
  assert_adv_match_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode) |=> flag_adv_ovf == (out_data[DATA_W-1] ^ out_data[DATA_W-2]));

endmodule

// File: tb/tb_sc_shift_top.sv
module tb_sc_shift_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, arith_mode;
  logic [31:0] in_data;
  logic [5:0]  in_count;
  logic [31:0] out_data;
  logic        flag_carry, flag_ovf, flag_sticky_ovf, flag_adv_ovf, flag_sticky_adv;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_res;
  logic m_c, m_v, m_sv, m_av, m_sav;

  always #4 clk = ~clk;

  sc_shift_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .arith_mode(arith_mode),
    .in_data(in_data), .in_count(in_count), .out_data(out_data),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf), .flag_sticky_ovf(flag_sticky_ovf),
    .flag_adv_ovf(flag_adv_ovf), .flag_sticky_adv(flag_sticky_adv)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic a, input logic [31:0] d, input int n);
    logic c, v;
    logic [31:0] r;
    c = 1'b0; v = 1'b0;
    if (!a) begin
      if (n == -32)   r = 32'h0;
      else if (n >= 0) r = d << n;
      else            r = d >> (-n);
    end else begin
      if (n == 0) begin
        r = d;
      end else if (n == -32) begin
        r = {32{d[31]}};
        c = (d != 32'h0);
      end else if (n > 0) begin
        r = d << n;
        for (int i = 32 - n; i < 32; i++) c = c | d[i];
        v = ($signed(d) > ($signed(32'h7FFFFFFF) >>> n)) ||
            ($signed(d) < ($signed(32'h80000000) >>> n));
      end else begin
        r = $signed(d) >>> (-n);
        for (int i = 0; i < -n; i++) c = c | d[i];
      end
    end
    m_res = r;
    if (a) begin
      m_c = c; m_v = v; m_sv = m_sv | v;
      m_av = r[31] ^ r[30]; m_sav = m_sav | m_av;
    end
  endtask

  task automatic op(input logic v, input logic a, input logic [31:0] d, input int n);
    string rt, ct, vt;
    in_valid = v; arith_mode = a; in_data = d; in_count = n[5:0];
    @(negedge clk);
    if (v) model(a, d, n);
    if (!v)            begin rt = "R10"; ct = "R10"; vt = "R10"; end
    else if (!a)       begin rt = "R2";  ct = "R9";  vt = "R9";  end
    else if (n == 0)   begin rt = "R7";  ct = "R7";  vt = "R7";  end
    else if (n == -32) begin rt = "R6";  ct = "R6";  vt = "R6";  end
    else if (n > 0)    begin rt = "R3";  ct = "R3";  vt = "R4";  end
    else               begin rt = "R5";  ct = "R5";  vt = "R5";  end
    chk(rt, "result", out_data, m_res);
    chk(ct, "carry", {31'b0, flag_carry}, {31'b0, m_c});
    chk(vt, "ovf", {31'b0, flag_ovf}, {31'b0, m_v});
    chk(vt, "sticky_ovf", {31'b0, flag_sticky_ovf}, {31'b0, m_sv});
    chk((v && !a) ? "R9" : "R8", "adv", {31'b0, flag_adv_ovf}, {31'b0, m_av});
    chk((v && !a) ? "R9" : "R8", "sticky_adv", {31'b0, flag_sticky_adv}, {31'b0, m_sav});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_res = '0; m_c = 0; m_v = 0; m_sv = 0; m_av = 0; m_sav = 0;
    rst = 1'b1; in_valid = 0; arith_mode = 0; in_data = '0; in_count = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "result", out_data, 32'h0);
    chk("R1", "flags", {27'b0, flag_carry, flag_ovf, flag_sticky_ovf, flag_adv_ovf, flag_sticky_adv}, 32'h0);

    // R2 logical corners (also R9: flags unchanged)
    op(1, 0, 32'hDEADBEEF, -32);
    op(1, 0, 32'h80000001, 31);
    op(1, 0, 32'h80000001, -31);
    op(1, 0, 32'hF0F0F0F0, -4);
    // R7 zero count
    op(1, 1, 32'hC0000000, 0);
    // R6 all-out right
    op(1, 1, 32'h00000000, -32);
    op(1, 1, 32'h80000000, -32);
    op(1, 1, 32'h00000001, -32);
    // R4 exact limits and one step past
    for (int n = 1; n < 32; n += 5) begin
      logic [31:0] hi, lo;
      hi = $signed(32'h7FFFFFFF) >>> n;
      lo = $signed(32'h80000000) >>> n;
      op(1, 1, hi, n);
      op(1, 1, lo, n);
      op(1, 1, hi + 32'd1, n);
      op(1, 1, lo - 32'd1, n);
    end
    // R4/R8 sticky survives a clean op and idle, R9 logical leaves flags
    op(1, 1, 32'h00000001, 1);
    op(0, 1, 32'hFFFFFFFF, 5);
    op(1, 0, 32'h40000000, 1);
    // R5 right arithmetic
    op(1, 1, 32'h80000003, -1);
    op(1, 1, 32'h7FFFFFFE, -31);
    // R3 carry from top bits
    op(1, 1, 32'h00000001, 31);
    op(1, 1, 32'h40000000, 2);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      int n, sel;
      sel = int'($urandom_range(0, 3));
      case (sel)
        0: d = $urandom;
        1: d = $urandom >> $urandom_range(0, 31);
        2: d = ~($urandom >> $urandom_range(0, 31));
        default: d = {$urandom_range(0, 1) == 1 ? 1'b1 : 1'b0, 31'h0} | ($urandom & 32'hFF);
      endcase
      n = int'($urandom_range(0, 63)) - 32;
      op($urandom_range(0, 7) != 0, $urandom_range(0, 3) != 0, d, n);
    end
    in_valid = 0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule